// File: doc/BRIEF.md
# Interlaced Field Vertical Timing Generator

This block produces the raster counters, active-region flags and sync strobes for a display controller that can run either progressive or interlaced. In interlaced operation it keeps two independently programmed vertical timing sets: one describes the odd field and the other the even field. It switches between them at every frame wrap, and it flags the field now being scanned.

Alongside the timing, the block reports the source image size that the pixel fetch path must expect. This size depends on the selected interlace mechanism and on whether the scaler is in use. The flicker filter mechanism cannot handle wide images. When it is requested for a wide image the block raises a configuration-error flag and falls back to per-field heights. All size inputs use the "size minus one" convention. Configuration inputs are treated as static registers. Vertical timing writes made in the middle of a field take effect at the next field.

Top module: `ilace_vtiming`

## Requirements
- R1: While `rst` is high, on each clock edge `h_cnt` and `v_cnt` go to 0 and `field` goes to 0 (odd). `hsync` goes to `hs_inv` and `vsync` goes to `vs_inv`, which are the inactive levels. The odd vertical set is loaded as the current set.
- R2: `h_cnt` counts 0..`h_total` and then returns to 0. `v_cnt` advances on each horizontal wrap. It returns to 0 on the horizontal wrap where it has reached the current field's total. At that point `h_cnt` and `v_cnt` are both 0 on the next cycle.
- R3: When `cfg_interlace`=1, `field` inverts at every frame wrap (0 = odd, 1 = even). At the same edge the new field's vertical set (active, total, sync start, sync end) is captured. A field therefore lasts (total+1)*(`h_total`+1) cycles. Writes to a set take effect only at the next wrap into that field.
- R4: When `cfg_interlace`=0, `field` becomes 0 at the next frame wrap and stays 0, and only the odd set is used.
- R5: `h_act` = (`h_cnt` <= `h_active`) and `v_act` = (`v_cnt` <= current vertical active). `de` is high when both are high.
- R6: `hsync` becomes (`hs_start` <= `h_cnt` <= `hs_end`) XOR `hs_inv` one cycle after the counter value. `vsync` behaves the same way, using `v_cnt` and the current field's sync start and end with `vs_inv`.
- R7: `src_w` equals `fb_w` when `cfg_scale`=1 and equals `h_active` otherwise.
- R8: Without the scaler, and with the flicker filter not in effect, `src_h` equals the current field's vertical active value. This covers progressive mode, `cfg_mech`=00 (interlaced addressing), and `cfg_mech`=10 or 11 (line repeat). Widths are zero-extended to CW+1 bits.
- R9: With `cfg_interlace`=1, `cfg_mech`=01 (flicker filter), no scaler and no error, `src_h` = `v_act_odd` + `v_act_even` + 1.
- R10: `cfg_err` is 1 exactly when `cfg_interlace`=1, `cfg_mech`=01 and the active width is over 1024 pixels. The width test uses `h_active` >= 1024, or `fb_w` >= 1024 when `cfg_scale`=1. In that case the filter is off and `src_h` follows R8 or R11.
- R11: With `cfg_scale`=1, `src_h` equals `fb_h`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_interlace | input | 1 | 1 = interlaced, 0 = progressive |
| cfg_mech | input | 2 | 00 interlaced addressing, 01 flicker filter, 10/11 line repeat |
| cfg_scale | input | 1 | Scaler enable |
| h_active | input | CW | Horizontal active width minus one |
| h_total | input | CW | Horizontal total minus one |
| hs_start | input | CW | Horizontal sync first pixel |
| hs_end | input | CW | Horizontal sync last pixel |
| v_act_odd | input | CW | Odd-field active lines minus one |
| v_tot_odd | input | CW | Odd-field total lines minus one |
| vs_start_odd | input | CW | Odd-field vertical sync first line |
| vs_end_odd | input | CW | Odd-field vertical sync last line |
| v_act_even | input | CW | Even-field active lines minus one |
| v_tot_even | input | CW | Even-field total lines minus one |
| vs_start_even | input | CW | Even-field vertical sync first line |
| vs_end_even | input | CW | Even-field vertical sync last line |
| fb_w | input | CW | Frame-buffer width minus one (scaler) |
| fb_h | input | CW | Frame-buffer height minus one (scaler) |
| hs_inv | input | 1 | Invert horizontal sync |
| vs_inv | input | 1 | Invert vertical sync |
| h_cnt | output | CW | Horizontal counter |
| v_cnt | output | CW | Vertical counter |
| field | output | 1 | 0 odd, 1 even |
| h_act | output | 1 | Horizontal active region |
| v_act | output | 1 | Vertical active region |
| de | output | 1 | Display enable |
| hsync | output | 1 | Registered horizontal sync |
| vsync | output | 1 | Registered vertical sync |
| src_w | output | CW | Pre-scale source width minus one |
| src_h | output | CW+1 | Pre-scale source height minus one |
| cfg_err | output | 1 | Flicker filter requested on too-wide image |

## Verification
The counters, `field` and the captured vertical set change on the clock edge itself. `h_act`, `v_act`, `de` and the field-dependent `src_h` follow them in the same cycle. The sync outputs trail the counter values by exactly one edge. `cfg_err`, `src_w` and the configuration part of `src_h` are combinational from the inputs. The bench changes inputs only on falling edges and samples every output on the following falling edge. A reference counter model advances once per rising edge and computes the sync level from the counter values held before that edge. Field lengths are measured in sampled cycles, so a field captured one edge late shows up as a length error.

// File: rtl/ilace_vtiming.sv
module ilace_vtiming #(
  parameter int CW       = 12,
  parameter int FF_MAX_W = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_interlace,
  input  logic [1:0]    cfg_mech,
  input  logic          cfg_scale,
  input  logic [CW-1:0] h_active,
  input  logic [CW-1:0] h_total,
  input  logic [CW-1:0] hs_start,
  input  logic [CW-1:0] hs_end,
  input  logic [CW-1:0] v_act_odd,
  input  logic [CW-1:0] v_tot_odd,
  input  logic [CW-1:0] vs_start_odd,
  input  logic [CW-1:0] vs_end_odd,
  input  logic [CW-1:0] v_act_even,
  input  logic [CW-1:0] v_tot_even,
  input  logic [CW-1:0] vs_start_even,
  input  logic [CW-1:0] vs_end_even,
  input  logic [CW-1:0] fb_w,
  input  logic [CW-1:0] fb_h,
  input  logic          hs_inv,
  input  logic          vs_inv,
  output logic [CW-1:0] h_cnt,
  output logic [CW-1:0] v_cnt,
  output logic          field,
  output logic          h_act,
  output logic          v_act,
  output logic          de,
  output logic          hsync,
  output logic          vsync,
  output logic [CW-1:0] src_w,
  output logic [CW:0]   src_h,
  output logic          cfg_err
);

  localparam logic [CW-1:0] FF_LIM  = CW'(FF_MAX_W - 1);
  localparam logic [1:0]    MECH_FF = 2'b01;

  logic [CW-1:0] cur_vact, cur_vtot, cur_vss, cur_vse;
  logic          h_wrap, v_wrap, nxt_field, hs_raw, vs_raw;
  logic          too_wide, ff_req, ff_on;

  assign h_wrap    = h_cnt >= h_total;
  assign v_wrap    = h_wrap && (v_cnt >= cur_vtot);
  assign nxt_field = cfg_interlace ? ~field : 1'b0;

  assign hs_raw = (h_cnt >= hs_start) && (h_cnt <= hs_end);
  assign vs_raw = (v_cnt >= cur_vss) && (v_cnt <= cur_vse);

  assign h_act = h_cnt <= h_active;
  assign v_act = v_cnt <= cur_vact;
  assign de    = h_act && v_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt    <= '0;
      v_cnt    <= '0;
      field    <= 1'b0;
      cur_vact <= v_act_odd;
      cur_vtot <= v_tot_odd;
      cur_vss  <= vs_start_odd;
      cur_vse  <= vs_end_odd;
      hsync    <= hs_inv;
      vsync    <= vs_inv;
    end else begin
      hsync <= hs_raw ^ hs_inv;
      vsync <= vs_raw ^ vs_inv;
      if (!h_wrap) begin
        h_cnt <= h_cnt + 1'b1;
      end else begin
        h_cnt <= '0;
        if (!v_wrap) begin
          v_cnt <= v_cnt + 1'b1;
        end else begin
          v_cnt <= '0;
          field <= nxt_field;
          cur_vact <= nxt_field ? v_act_even    : v_act_odd;
          cur_vtot <= nxt_field ? v_tot_even    : v_tot_odd;
          cur_vss  <= nxt_field ? vs_start_even : vs_start_odd;
          cur_vse  <= nxt_field ? vs_end_even   : vs_end_odd;
        end
      end
    end
  end

  assign too_wide = (h_active > FF_LIM) || (cfg_scale && (fb_w > FF_LIM));
  assign ff_req   = cfg_interlace && (cfg_mech == MECH_FF);
  assign cfg_err  = ff_req && too_wide;
  assign ff_on    = ff_req && !too_wide;

  assign src_w = cfg_scale ? fb_w : h_active;
  assign src_h = cfg_scale ? {1'b0, fb_h}
               : ff_on     ? ({1'b0, v_act_odd} + {1'b0, v_act_even} + (CW+1)'(1))
               :             {1'b0, cur_vact};

  // R2
  vbound_chk: assert property (@(posedge clk) disable iff (rst)
    v_cnt <= cur_vtot);

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    v_wrap |=> (h_cnt == '0) && (v_cnt == '0));

  // R3
  field_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (v_wrap && cfg_interlace) |=> (field != $past(field)));

  // R3
  field_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !v_wrap |=> $stable(field));

  // R4
  field_prog_chk: assert property (@(posedge clk) disable iff (rst)
    (v_wrap && !cfg_interlace) |=> !field);

  // R10
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !cfg_scale) |-> (src_h == {1'b0, cur_vact}));

endmodule

// File: tb/ilace_vtiming_test.sv
module ilace_vtiming_test;
  localparam int CW = 12;

  logic clk = 0, rst = 1;
  logic cfg_interlace = 0, cfg_scale = 0, hs_inv = 0, vs_inv = 0;
  logic [1:0] cfg_mech = 0;
  logic [CW-1:0] h_active = 0, h_total = 0, hs_start = 0, hs_end = 0;
  logic [CW-1:0] v_act_odd = 0, v_tot_odd = 0, vs_start_odd = 0, vs_end_odd = 0;
  logic [CW-1:0] v_act_even = 0, v_tot_even = 0, vs_start_even = 0, vs_end_even = 0;
  logic [CW-1:0] fb_w = 0, fb_h = 0;
  logic [CW-1:0] h_cnt, v_cnt, src_w;
  logic [CW:0] src_h;
  logic field, h_act, v_act, de, hsync, vsync, cfg_err;

  ilace_vtiming #(.CW(CW)) uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // il, mech, scale, h_active, fb_w, exp_w, exp_h, exp_err
  localparam int NV = 11;
  localparam logic [53:0] TBL [NV] = '{
    {1'b0, 2'd0, 1'b0, 12'd719,  12'd0,    12'd719,  13'd239, 1'b0},
    {1'b1, 2'd0, 1'b0, 12'd719,  12'd0,    12'd719,  13'd239, 1'b0},
    {1'b1, 2'd1, 1'b0, 12'd719,  12'd0,    12'd719,  13'd480, 1'b0},
    {1'b1, 2'd1, 1'b0, 12'd1023, 12'd0,    12'd1023, 13'd480, 1'b0},
    {1'b1, 2'd1, 1'b0, 12'd1024, 12'd0,    12'd1024, 13'd239, 1'b1},
    {1'b1, 2'd1, 1'b1, 12'd719,  12'd1024, 12'd1024, 13'd99,  1'b1},
    {1'b1, 2'd1, 1'b1, 12'd719,  12'd1023, 12'd1023, 13'd99,  1'b0},
    {1'b0, 2'd1, 1'b0, 12'd1200, 12'd0,    12'd1200, 13'd239, 1'b0},
    {1'b1, 2'd2, 1'b0, 12'd719,  12'd0,    12'd719,  13'd239, 1'b0},
    {1'b0, 2'd0, 1'b1, 12'd719,  12'd639,  12'd639,  13'd99,  1'b0},
    {1'b1, 2'd1, 1'b0, 12'd719,  12'd2000, 12'd719,  13'd480, 1'b0}
  };

  int mh, mv, mact, mtot, mss, mse;
  bit mf, mhs, mvs;

  task automatic load_set(input bit f);
    mact = f ? v_act_even    : v_act_odd;
    mtot = f ? v_tot_even    : v_tot_odd;
    mss  = f ? vs_start_even : vs_start_odd;
    mse  = f ? vs_end_even   : vs_end_odd;
  endtask

  task automatic model_step();
    mhs = ((mh >= hs_start) && (mh <= hs_end)) ^ hs_inv;
    mvs = ((mv >= mss) && (mv <= mse)) ^ vs_inv;
    if (mh == h_total) begin
      mh = 0;
      if (mv == mtot) begin
        mv = 0;
        mf = cfg_interlace ? ~mf : 1'b0;
        load_set(mf);
      end else mv++;
    end else mh++;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int even_run, even_idx;
    int even_len [2];
    int prog_f1;
    v_act_odd = 239; v_act_even = 240; fb_h = 99;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 h_cnt", h_cnt, 0);
    chk("R1 v_cnt", v_cnt, 0);
    chk("R1 field", field, 0);
    chk("R1 hsync", hsync, 0);
    chk("R1 vsync", vsync, 0);
    hs_inv = 1; vs_inv = 1;
    @(negedge clk);
    chk("R1 hsync inverted", hsync, 1);
    chk("R1 vsync inverted", vsync, 1);
    hs_inv = 0; vs_inv = 0;

    // R7 R8 R9 R10 R11 configuration vectors
    for (int i = 0; i < NV; i++) begin
      {cfg_interlace, cfg_mech, cfg_scale, h_active, fb_w} = TBL[i][53:26];
      @(negedge clk);
      chk($sformatf("R7 src_w vec%0d", i), src_w, TBL[i][25:14]);
      chk($sformatf("R8/R9/R11 src_h vec%0d", i), src_h, TBL[i][13:1]);
      chk($sformatf("R10 cfg_err vec%0d", i), cfg_err, TBL[i][0]);
    end

    // timing run
    cfg_interlace = 1; cfg_mech = 0; cfg_scale = 0;
    h_total = 9; h_active = 5; hs_start = 7; hs_end = 8;
    v_act_odd = 3; v_tot_odd = 5; vs_start_odd = 4; vs_end_odd = 4;
    v_act_even = 2; v_tot_even = 6; vs_start_even = 5; vs_end_even = 5;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    mh = 0; mv = 0; mf = 0; mhs = 0; mvs = 0;
    load_set(0);
    even_run = 0; even_idx = 0; prog_f1 = 0;
    for (int n = 1; n <= 500; n++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk($sformatf("R2 h_cnt n%0d", n), h_cnt, mh);
      chk($sformatf("R2 v_cnt n%0d", n), v_cnt, mv);
      chk($sformatf("R3 field n%0d", n), field, mf);
      chk($sformatf("R5 h_act n%0d", n), h_act, mh <= h_active);
      chk($sformatf("R5 v_act n%0d", n), v_act, mv <= mact);
      chk($sformatf("R5 de n%0d", n), de, (mh <= h_active) && (mv <= mact));
      chk($sformatf("R6 hsync n%0d", n), hsync, mhs);
      chk($sformatf("R6 vsync n%0d", n), vsync, mvs);
      chk($sformatf("R8 src_h n%0d", n), src_h, mact);
      if (field) even_run++;
      else if (even_run != 0) begin
        if (even_idx < 2) even_len[even_idx] = even_run;
        even_idx++;
        even_run = 0;
      end
      if (n > 300 && field) prog_f1++;
      if (n == 80) begin v_tot_even = 4; vs_start_even = 3; vs_end_even = 3; end
      if (n == 150) begin hs_inv = 1; vs_inv = 1; end
      if (n == 260) cfg_interlace = 0;
    end
    // R3 field lengths: (6+1)*10 then, after mid-field write, (4+1)*10
    chk("R3 first even field length", even_len[0], 70);
    chk("R3 even field length after mid-field write", even_len[1], 50);
    chk("R3 even field count", even_idx, 2);
    // R4 progressive: field stays odd
    chk("R4 field held odd", prog_f1, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule